// File: doc/BRIEF.md
# Character LCD Parallel Write Controller

This block sits between user logic and an 8-bit parallel character display module that understands the common character-LCD command set. When reset is released it waits a long settling delay for the display's supply to stabilise. It then writes a short, fixed start-up command list that puts the display into 8-bit mode with the configured line count, font, display, cursor and entry behaviour. After that it serves user writes.

User logic places a 10-bit word on `wr_word` and pulses `wr_strobe` while `busy` is low. The word is taken on that clock edge and turned into one enable-strobed bus write. `busy` then stays high for a fixed send slot. Every delay is given in microseconds and converted into clock cycles from the `CLK_HZ` parameter, so the same code fits any system clock. The display's own busy flag is never read. The slots are sized so that every command finishes inside its own window.

Top module: `char_lcd_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block holds `busy`=1 and `lcd_e`=0, and `lcd_rs`, `lcd_rw` and `lcd_db` are all 0.
- R2: After `rst` falls, no enable pulse appears for `POWERUP_US` microseconds. The first enable rise comes exactly at cycle PWR+1+CPU after release, where CPU = ceil(CLK_HZ/1e6) and PWR = POWERUP_US·CPU.
- R3: The start-up list is exactly four writes with RS=0 and RW=0, in this order: function set 0x30|LINES2<<3|FONT_TALL<<2, display control 0x08|DISP_ON<<2|CURSOR_ON<<1|BLINK_ON, clear 0x01, entry mode 0x04|ADDR_INC<<1|SCROLL<<0.
- R4: Each start-up command occupies one issue cycle plus a slot of CMD_US·CPU cycles. The clear command's slot is CLEAR_US·CPU cycles instead. `busy` falls exactly PWR + 4 + the sum of the slots cycles after reset release.
- R5: `busy` is low only while the block is idle and waiting. A `wr_strobe` seen high at an edge while idle captures `wr_word` and produces exactly one enable pulse. Bit 9 of `wr_word` drives `lcd_rs`, bit 8 drives `lcd_rw`, and bits 7..0 drive `lcd_db`.
- R6: After a captured write, `busy` stays high for exactly SEND_US·CPU cycles and then falls.
- R7: `lcd_rs`, `lcd_rw` and `lcd_db` hold their value in the cycle before `lcd_e` rises, for the whole time `lcd_e` is high, and across its fall. `lcd_e` stays high for at least CPU cycles (1 us).
- R8: `wr_strobe` pulses while `busy` is high produce no enable pulse and leave `lcd_db`, `lcd_rs` and `lcd_rw` unchanged.
- R9: Raising `rst` at any time, even in the middle of a write, returns the block to the power-up wait. After release it runs the full start-up list again with the timing of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | Write request, taken when `busy` is low |
| wr_word | input | 10 | {RS, RW, data[7:0]} for the requested write |
| busy | output | 1 | High during power-up, start-up and each write slot |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write select to the display |
| lcd_e | output | 1 | Enable strobe to the display |
| lcd_db | output | 8 | Data bus to the display |

## Verification
The bench builds the block with CLK_HZ = 2 MHz, which gives two cycles per microsecond. It also uses POWERUP_US = 100, CMD_US = 50, CLEAR_US = 200 and SEND_US = 50. With these values the power-up wait and the whole start-up list, including a second run after a mid-write reset, finish in under a thousand cycles each. The exact cycle counts of R2, R4 and R6 can therefore be compared directly. Because a microsecond is two cycles, the enable setup and pulse windows are short enough that an off-by-one in the strobe timing shows up as a measured width or a wrong rise cycle.

// File: rtl/char_lcd_pkg.sv
package char_lcd_pkg;

  localparam int WORD_W = 10;
  localparam int DB_W   = 8;

  typedef enum logic [2:0] {
    ST_PWRUP      = 3'd0,
    ST_INIT_ISSUE = 3'd1,
    ST_INIT_WAIT  = 3'd2,
    ST_READY      = 3'd3,
    ST_SEND       = 3'd4
  } ctrl_state_t;

  typedef struct packed {
    logic            rs;
    logic            rw;
    logic [DB_W-1:0] code;
  } lcd_word_t;

  function automatic int cyc_per_us(input int clk_hz);
    return (clk_hz + 999_999) / 1_000_000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_delay_counter.sv
module lcd_delay_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  assign expired = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import char_lcd_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int CMD_CYC   = 100,
  parameter int CLEAR_CYC = 400,
  parameter bit LINES2    = 1'b1,
  parameter bit FONT_TALL = 1'b0,
  parameter bit DISP_ON   = 1'b1,
  parameter bit CURSOR_ON = 1'b0,
  parameter bit BLINK_ON  = 1'b0,
  parameter bit ADDR_INC  = 1'b1,
  parameter bit SCROLL    = 1'b0
) (
  input  logic [1:0]        idx,
  output lcd_word_t         word,
  output logic [SLOT_W-1:0] slot_len
);
  localparam logic [7:0] FN_SET   = 8'h30 | (8'(LINES2) << 3) | (8'(FONT_TALL) << 2);
  localparam logic [7:0] DISP_CTL = 8'h08 | (8'(DISP_ON) << 2) | (8'(CURSOR_ON) << 1)
                                          | 8'(BLINK_ON);
  localparam logic [7:0] CLR      = 8'h01;
  localparam logic [7:0] ENTRY    = 8'h04 | (8'(ADDR_INC) << 1) | 8'(SCROLL);

  always_comb begin
    word.rs  = 1'b0;
    word.rw  = 1'b0;
    slot_len = SLOT_W'(CMD_CYC);
    case (idx)
      2'd0: word.code = FN_SET;
      2'd1: word.code = DISP_CTL;
      2'd2: begin
        word.code = CLR;
        slot_len  = SLOT_W'(CLEAR_CYC);
      end
      default: word.code = ENTRY;
    endcase
  end

endmodule

// File: rtl/lcd_bus_phy.sv
module lcd_bus_phy
  import char_lcd_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  lcd_word_t         word_in,
  input  logic [SLOT_W-1:0] slot_len,
  output logic              done,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_e,
  output logic [DB_W-1:0]   lcd_db
);
  localparam logic [SLOT_W-1:0] E_ON  = SLOT_W'(SETUP_CYC);
  localparam logic [SLOT_W-1:0] E_OFF = SLOT_W'(SETUP_CYC + PULSE_CYC);

  logic              active;
  logic [SLOT_W-1:0] cnt;
  logic [SLOT_W-1:0] len_q;
  logic [SLOT_W-1:0] cnt_nx;
  logic              run_nx;

  assign done = active && (cnt == len_q - 1'b1);

  always_comb begin
    cnt_nx = start ? '0 : cnt + 1'b1;
    run_nx = start || (active && !done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      lcd_rs <= 1'b0;
      lcd_rw <= 1'b0;
      lcd_db <= '0;
      lcd_e  <= 1'b0;
    end else begin
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        len_q  <= slot_len;
        lcd_rs <= word_in.rs;
        lcd_rw <= word_in.rw;
        lcd_db <= word_in.code;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (done) active <= 1'b0;
      end
      lcd_e <= run_nx && (cnt_nx >= E_ON) && (cnt_nx < E_OFF);
    end
  end

  assert_e_setup_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_e) |-> $stable({lcd_rs, lcd_rw, lcd_db}));

  assert_e_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (lcd_e || $fell(lcd_e)) |-> $stable({lcd_rs, lcd_rw, lcd_db}));

  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < len_q));

endmodule

// File: rtl/char_lcd_ctrl.sv
module char_lcd_ctrl
  import char_lcd_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int POWERUP_US = 50_000,
  parameter int CMD_US     = 50,
  parameter int CLEAR_US   = 2_000,
  parameter int SEND_US    = 50,
  parameter bit LINES2     = 1'b1,
  parameter bit FONT_TALL  = 1'b0,
  parameter bit DISP_ON    = 1'b1,
  parameter bit CURSOR_ON  = 1'b0,
  parameter bit BLINK_ON   = 1'b0,
  parameter bit ADDR_INC   = 1'b1,
  parameter bit SCROLL     = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_strobe,
  input  logic [WORD_W-1:0] wr_word,
  output logic              busy,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_e,
  output logic [DB_W-1:0]   lcd_db
);
  localparam int CPU       = cyc_per_us(CLK_HZ);
  localparam int PWR_CYC   = POWERUP_US * CPU;
  localparam int CMD_CYC   = CMD_US * CPU;
  localparam int CLEAR_CYC = CLEAR_US * CPU;
  localparam int SEND_CYC  = SEND_US * CPU;
  localparam int MAX_SLOT  = imax(imax(CMD_CYC, CLEAR_CYC), SEND_CYC);
  localparam int SLOT_W    = $clog2(MAX_SLOT + 1);
  localparam logic [1:0] LAST_INIT = 2'd3;

  ctrl_state_t       state, state_nx;
  logic [1:0]        init_idx;
  logic              pwr_done;
  logic              phy_start;
  logic              phy_done;
  lcd_word_t         phy_word;
  lcd_word_t         init_word;
  logic [SLOT_W-1:0] phy_len;
  logic [SLOT_W-1:0] init_len;

  lcd_delay_counter #(.LIMIT(PWR_CYC)) u_pwr_wait (
    .clk     (clk),
    .rst     (rst),
    .en      (state == ST_PWRUP),
    .expired (pwr_done)
  );

  lcd_init_seq #(
    .SLOT_W    (SLOT_W),
    .CMD_CYC   (CMD_CYC),
    .CLEAR_CYC (CLEAR_CYC),
    .LINES2    (LINES2),
    .FONT_TALL (FONT_TALL),
    .DISP_ON   (DISP_ON),
    .CURSOR_ON (CURSOR_ON),
    .BLINK_ON  (BLINK_ON),
    .ADDR_INC  (ADDR_INC),
    .SCROLL    (SCROLL)
  ) u_init_seq (
    .idx      (init_idx),
    .word     (init_word),
    .slot_len (init_len)
  );

  lcd_bus_phy #(
    .SLOT_W    (SLOT_W),
    .SETUP_CYC (CPU),
    .PULSE_CYC (CPU)
  ) u_phy (
    .clk      (clk),
    .rst      (rst),
    .start    (phy_start),
    .word_in  (phy_word),
    .slot_len (phy_len),
    .done     (phy_done),
    .lcd_rs   (lcd_rs),
    .lcd_rw   (lcd_rw),
    .lcd_e    (lcd_e),
    .lcd_db   (lcd_db)
  );

  always_comb begin
    state_nx  = state;
    phy_start = 1'b0;
    phy_word  = init_word;
    phy_len   = init_len;
    case (state)
      ST_PWRUP: begin
        if (pwr_done) state_nx = ST_INIT_ISSUE;
      end
      ST_INIT_ISSUE: begin
        phy_start = 1'b1;
        state_nx  = ST_INIT_WAIT;
      end
      ST_INIT_WAIT: begin
        if (phy_done) state_nx = (init_idx == LAST_INIT) ? ST_READY : ST_INIT_ISSUE;
      end
      ST_READY: begin
        if (wr_strobe) begin
          phy_start = 1'b1;
          phy_word  = lcd_word_t'(wr_word);
          phy_len   = SLOT_W'(SEND_CYC);
          state_nx  = ST_SEND;
        end
      end
      ST_SEND: begin
        if (phy_done) state_nx = ST_READY;
      end
      default: state_nx = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PWRUP;
      init_idx <= '0;
      busy     <= 1'b1;
    end else begin
      state <= state_nx;
      busy  <= (state_nx != ST_READY);
      if (state == ST_INIT_WAIT && phy_done && init_idx != LAST_INIT)
        init_idx <= init_idx + 1'b1;
    end
  end

  assert_idle_only_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (state == ST_READY));

  assert_quiet_powerup_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PWRUP) |-> !lcd_e);

  assert_init_ends_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT_WAIT && phy_done && init_idx == LAST_INIT) |=> (state == ST_READY));

  assert_busy_in_send_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND) |-> busy);

endmodule

// File: tb/char_lcd_ctrl_bench.sv
module char_lcd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2_000_000;
  localparam int POWERUP_US = 100;
  localparam int CMD_US     = 50;
  localparam int CLEAR_US   = 200;
  localparam int SEND_US    = 50;
  localparam bit LINES2     = 1'b1;
  localparam bit FONT_TALL  = 1'b0;
  localparam bit DISP_ON    = 1'b1;
  localparam bit CURSOR_ON  = 1'b1;
  localparam bit BLINK_ON   = 1'b0;
  localparam bit ADDR_INC   = 1'b1;
  localparam bit SCROLL     = 1'b0;

  localparam int CPU      = (CLK_HZ + 999_999) / 1_000_000;
  localparam int PWR      = POWERUP_US * CPU;
  localparam int SEND_CYC = SEND_US * CPU;
  localparam int INIT_TOT = PWR + 4 + 3 * CMD_US * CPU + CLEAR_US * CPU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_strobe = 1'b0;
  logic [9:0] wr_word = '0;
  logic       busy, lcd_rs, lcd_rw, lcd_e;
  logic [7:0] lcd_db;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [9:0] rec [0:15];
  int   rises = 0;
  int   rises_since_rst = 0;
  int   first_rise_cyc = -1;
  int   setup_bad = 0;
  int   hold_bad = 0;
  int   min_pulse = 1_000_000;
  int   pulse_w = 0;
  logic prev_e = 1'b0;
  logic [9:0] prev_bus = '0;

  char_lcd_ctrl #(
    .CLK_HZ(CLK_HZ), .POWERUP_US(POWERUP_US), .CMD_US(CMD_US),
    .CLEAR_US(CLEAR_US), .SEND_US(SEND_US), .LINES2(LINES2),
    .FONT_TALL(FONT_TALL), .DISP_ON(DISP_ON), .CURSOR_ON(CURSOR_ON),
    .BLINK_ON(BLINK_ON), .ADDR_INC(ADDR_INC), .SCROLL(SCROLL)
  ) u_char_lcd_ctrl (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_word(wr_word),
    .busy(busy), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    logic [9:0] bus;
    bus = {lcd_rs, lcd_rw, lcd_db};
    if (rst) begin
      rises_since_rst = 0;
      first_rise_cyc  = -1;
      pulse_w         = 0;
    end else begin
      if (lcd_e && !prev_e) begin
        if (bus != prev_bus) setup_bad++;
        if (rises_since_rst == 0) first_rise_cyc = cyc;
        rec[rises % 16] = bus;
        rises++;
        rises_since_rst++;
        pulse_w = 1;
      end else if (lcd_e) begin
        pulse_w++;
        if (bus != prev_bus) hold_bad++;
      end else if (prev_e) begin
        if (bus != prev_bus) hold_bad++;
        if (pulse_w < min_pulse) min_pulse = pulse_w;
      end
    end
    prev_e   = lcd_e;
    prev_bus = bus;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  // Releases reset and waits for busy to drop, pulsing the strobe meanwhile.
  task automatic bring_up(output int n);
    n = 0;
    @(negedge clk);
    rst = 1'b0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!busy) begin
        wr_strobe = 1'b0;
        break;
      end
      wr_strobe = ((n % 37) == 5);
      wr_word   = 10'h3A5;
    end while (n < 20000);
  endtask

  task automatic send_word(input logic [9:0] w, output int n);
    @(negedge clk);
    wr_word   = w;
    wr_strobe = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      wr_strobe = 1'b0;
    end while (busy && n < 20000);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
    check(lcd_e == 1'b0, "R1", "lcd_e in reset", int'(lcd_e), 0);
    check({lcd_rs, lcd_rw, lcd_db} == 10'h000, "R1", "bus in reset",
          int'({lcd_rs, lcd_rw, lcd_db}), 0);
  endtask

  task automatic t_startup(input string req);
    int n;
    int base;
    logic [7:0] exp_w [0:3];
    base = rises;
    exp_w[0] = 8'h30 | (8'(LINES2) << 3) | (8'(FONT_TALL) << 2);
    exp_w[1] = 8'h08 | (8'(DISP_ON) << 2) | (8'(CURSOR_ON) << 1) | 8'(BLINK_ON);
    exp_w[2] = 8'h01;
    exp_w[3] = 8'h04 | (8'(ADDR_INC) << 1) | 8'(SCROLL);
    bring_up(n);
    check(n == INIT_TOT, req, "cycles until busy falls (R4)", n, INIT_TOT);
    check(first_rise_cyc == PWR + 1 + CPU, req, "first enable rise cycle (R2)",
          first_rise_cyc, PWR + 1 + CPU);
    check(rises - base == 4, req, "start-up write count, strobes ignored (R3 R8)",
          rises - base, 4);
    for (int i = 0; i < 4; i++)
      check(rec[(base + i) % 16] == {2'b00, exp_w[i]}, req, "start-up word (R3)",
            int'(rec[(base + i) % 16]), int'({2'b00, exp_w[i]}));
  endtask

  task automatic t_write(input logic [9:0] w);
    int n;
    int base;
    base = rises;
    send_word(w, n);
    check(n == SEND_CYC + 1, "R6", "send slot length", n - 1, SEND_CYC);
    check(rises - base == 1, "R5", "one enable pulse per write", rises - base, 1);
    check(rec[base % 16] == w, "R5", "word seen at enable rise",
          int'(rec[base % 16]), int'(w));
  endtask

  task automatic t_ignore_busy();
    int base;
    logic [9:0] w;
    w = 10'h2C3;
    base = rises;
    @(negedge clk);
    wr_word   = w;
    wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      wr_word   = 10'h155 ^ 10'(k);
      wr_strobe = (k % 3 == 0);
    end
    wr_strobe = 1'b0;
    while (busy) @(negedge clk);
    check(rises - base == 1, "R8", "pulses while busy add no write", rises - base, 1);
    check({lcd_rs, lcd_rw, lcd_db} == w, "R8", "bus keeps first word",
          int'({lcd_rs, lcd_rw, lcd_db}), int'(w));
  endtask

  task automatic t_timing();
    check(setup_bad == 0, "R7", "bus change at enable rise", setup_bad, 0);
    check(hold_bad == 0, "R7", "bus change while enable high or at fall", hold_bad, 0);
    check(min_pulse >= CPU, "R7", "minimum enable width", min_pulse, CPU);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    wr_word   = 10'h241;
    wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy after mid-write reset", int'(busy), 1);
    check({lcd_e, lcd_rs, lcd_rw, lcd_db} == 11'h000, "R9", "outputs after reset",
          int'({lcd_e, lcd_rs, lcd_rw, lcd_db}), 0);
    t_startup("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_startup("R4");
    t_write(10'h241);
    t_write(10'h080);
    t_write(10'h3FF);
    t_write(10'h100);
    t_ignore_busy();
    t_mid_reset();
    t_write(10'h26D);
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule